// File: doc/BRIEF.md
# ISA Slave Bus-Width Decoder

This block is the address decode front end of a 16-bit expansion card on the ISA bus. It watches the unlatched high address lines and the low I/O address lines. From the address alone, with no knowledge of the cycle type, it raises two width indications, one for memory and one for I/O. The card drives these onto the bus as open-drain, active-low lines. Because memory and I/O share the address lines, one address can match both decodes, and then both indications are active at once. The host looks only at the indication that belongs to the cycle it actually runs.

The block also produces four internal chip selects for the device logic behind it: memory read, memory write, I/O read and I/O write. Each select is qualified by the six command strobes. The I/O selects are also qualified by the DMA address-enable line, so the card ignores addresses that the DMA controller owns. The 128 KB memory window base and the 8-port I/O block base are parameters.

All outputs are registered on the card's local clock. Each one therefore reflects the bus inputs one clock after they are applied. An open-drain line is modelled as an output enable, with the driven data value fixed at low.

Top module: `isa_width_decoder`

## Requirements
- R1: While reset is held, and in the first sample after reset releases with no bus activity, all six outputs (mem16_oe, io16_oe, mem_rd_cs, mem_wr_cs, io_rd_cs, io_wr_cs) are 0.
- R2: mem16_oe is 1 exactly one clock after la_hi (address bits 23:17) equals MEM_BASE, and 0 otherwise. Strobes and aen have no effect on it.
- R3: io16_oe is 1 exactly one clock after sa_hi (port address bits 9:3) equals bits 9:3 of IO_BASE, and 0 otherwise. Strobes and aen have no effect on it.
- R4: When the address matches both the memory window and the I/O block, mem16_oe and io16_oe are both 1 in the same cycle.
- R5: mem_rd_cs is 1 one clock after a window match with memr_n low. It is also 1 after a window match with smemr_n low, provided the window lies in the first megabyte (MEM_BASE bits 6:3 zero).
- R6: mem_wr_cs follows the same rule as R5, using memw_n and smemw_n.
- R7: io_rd_cs is 1 one clock after an I/O block match with aen low and ior_n low. io_wr_cs follows the same rule with iow_n.
- R8: While aen is 1, io_rd_cs and io_wr_cs stay 0 even when the I/O block matches and a strobe is low. The memory selects are not affected by aen.
- R9: For a window above the first megabyte (MEM_BASE bits 6:3 nonzero), smemr_n and smemw_n have no effect: mem_rd_cs and mem_wr_cs stay 0 on them.
- R10: With every strobe high (address-only phase), all four chip selects are 0, even when the width indications are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| la_hi | input | 7 | Unlatched address bits 23:17 |
| sa_hi | input | 7 | Port address bits 9:3 |
| aen | input | 1 | DMA address enable, high in DMA cycles |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| smemr_n | input | 1 | First-megabyte memory read strobe, active low |
| smemw_n | input | 1 | First-megabyte memory write strobe, active low |
| memr_n | input | 1 | Full-range memory read strobe, active low |
| memw_n | input | 1 | Full-range memory write strobe, active low |
| mem16_oe | output | 1 | Drive the memory-width line low |
| io16_oe | output | 1 | Drive the I/O-width line low |
| mem_rd_cs | output | 1 | Memory read select |
| mem_wr_cs | output | 1 | Memory write select |
| io_rd_cs | output | 1 | I/O read select |
| io_wr_cs | output | 1 | I/O write select |

## Verification
The memory-width and I/O-width indications can both be active in the same cycle. The bench provokes this by putting an address on the bus that lies inside the memory window and also aliases into the I/O block, with every strobe held high. It expects both enables to be 1 at the following sample, and all selects to be 0. The same overlapping address is then repeated with a single memory strobe, and then with a single I/O strobe under both levels of aen. In each case exactly the select that matches the cycle type must rise, while both width enables stay asserted.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;

    // Registered output bundle of the decoder
    typedef struct packed {
        logic mem16;
        logic io16;
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
    } dec_out_t;

    localparam dec_out_t DEC_IDLE = '{default: 1'b0};

endpackage

// File: rtl/isa_mem_match.sv
module isa_mem_match #(
    parameter int          LA_W     = 7,
    parameter int          LA_LSB   = 17,
    parameter logic [6:0]  MEM_BASE = 7'h06
) (
    input  logic [LA_W-1:0] la_hi,
    output logic            win_hit,
    output logic            lo_mb_hit
);
    // number of la_hi bits that sit below the 1 MB boundary
    localparam int LOMB_BITS = 20 - LA_LSB;
    localparam int UP_W      = LA_W - LOMB_BITS;
    localparam logic [LA_W-1:0] BASE = MEM_BASE[LA_W-1:0];
    localparam bit IN_FIRST_MB = (BASE[LA_W-1:LOMB_BITS] == {UP_W{1'b0}});

    // pure address compare, no cycle information
    assign win_hit = (la_hi == BASE);

    generate
        if (IN_FIRST_MB) begin : g_lomb
            assign lo_mb_hit = win_hit;
        end else begin : g_himb
            assign lo_mb_hit = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/isa_io_match.sv
module isa_io_match #(
    parameter int          IO_DEC_BITS = 10,
    parameter int          IO_BLK_LOG2 = 3,
    parameter logic [9:0]  IO_BASE     = 10'h300
) (
    input  logic [IO_DEC_BITS-IO_BLK_LOG2-1:0] sa_hi,
    output logic                               blk_hit
);
    localparam int HI_W = IO_DEC_BITS - IO_BLK_LOG2;
    localparam logic [HI_W-1:0] BASE_HI = IO_BASE[IO_DEC_BITS-1:IO_BLK_LOG2];

    // partial decode: only the low port bits take part
    assign blk_hit = (sa_hi == BASE_HI);

endmodule

// File: rtl/isa_strobe_qual.sv
module isa_strobe_qual
    import isa_dec_pkg::*;
(
    input  logic     win_hit,
    input  logic     lo_mb_hit,
    input  logic     blk_hit,
    input  logic     aen,
    input  logic     ior_n,
    input  logic     iow_n,
    input  logic     smemr_n,
    input  logic     smemw_n,
    input  logic     memr_n,
    input  logic     memw_n,
    output dec_out_t dec_d
);
    logic io_ok;

    always_comb begin
        io_ok        = blk_hit && !aen;
        dec_d        = DEC_IDLE;
        dec_d.mem16  = win_hit;
        dec_d.io16   = blk_hit;
        dec_d.mem_rd = (win_hit && !memr_n) || (lo_mb_hit && !smemr_n);
        dec_d.mem_wr = (win_hit && !memw_n) || (lo_mb_hit && !smemw_n);
        dec_d.io_rd  = io_ok && !ior_n;
        dec_d.io_wr  = io_ok && !iow_n;
    end

endmodule

// File: rtl/isa_width_decoder.sv
module isa_width_decoder
    import isa_dec_pkg::*;
#(
    parameter logic [6:0] MEM_BASE    = 7'h06,
    parameter logic [9:0] IO_BASE     = 10'h300,
    parameter int         IO_DEC_BITS = 10,
    parameter int         IO_BLK_LOG2 = 3,
    parameter int         LA_W        = 7,
    parameter int         LA_LSB      = 17,
    localparam int        SA_HI_W     = IO_DEC_BITS - IO_BLK_LOG2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LA_W-1:0]    la_hi,
    input  logic [SA_HI_W-1:0] sa_hi,
    input  logic               aen,
    input  logic               ior_n,
    input  logic               iow_n,
    input  logic               smemr_n,
    input  logic               smemw_n,
    input  logic               memr_n,
    input  logic               memw_n,
    output logic               mem16_oe,
    output logic               io16_oe,
    output logic               mem_rd_cs,
    output logic               mem_wr_cs,
    output logic               io_rd_cs,
    output logic               io_wr_cs
);
    logic     win_hit;
    logic     lo_mb_hit;
    logic     blk_hit;
    dec_out_t dec_d;
    dec_out_t dec_q;

    isa_mem_match #(
        .LA_W    (LA_W),
        .LA_LSB  (LA_LSB),
        .MEM_BASE(MEM_BASE)
    ) mem_match_i (
        .la_hi    (la_hi),
        .win_hit  (win_hit),
        .lo_mb_hit(lo_mb_hit)
    );

    isa_io_match #(
        .IO_DEC_BITS(IO_DEC_BITS),
        .IO_BLK_LOG2(IO_BLK_LOG2),
        .IO_BASE    (IO_BASE)
    ) io_match_i (
        .sa_hi  (sa_hi),
        .blk_hit(blk_hit)
    );

    isa_strobe_qual qual_i (
        .win_hit  (win_hit),
        .lo_mb_hit(lo_mb_hit),
        .blk_hit  (blk_hit),
        .aen      (aen),
        .ior_n    (ior_n),
        .iow_n    (iow_n),
        .smemr_n  (smemr_n),
        .smemw_n  (smemw_n),
        .memr_n   (memr_n),
        .memw_n   (memw_n),
        .dec_d    (dec_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= DEC_IDLE;
        else        dec_q <= dec_d;
    end

    assign mem16_oe  = dec_q.mem16;
    assign io16_oe   = dec_q.io16;
    assign mem_rd_cs = dec_q.mem_rd;
    assign mem_wr_cs = dec_q.mem_wr;
    assign io_rd_cs  = dec_q.io_rd;
    assign io_wr_cs  = dec_q.io_wr;

endmodule

// File: rtl/isa_width_decoder_chk.sv
module isa_width_decoder_chk #(
    parameter logic [6:0] MEM_BASE = 7'h06,
    parameter int         LA_W     = 7,
    parameter int         SA_HI_W  = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LA_W-1:0]    la_hi,
    input logic [SA_HI_W-1:0] sa_hi,
    input logic               aen,
    input logic               ior_n,
    input logic               iow_n,
    input logic               memr_n,
    input logic               memw_n,
    input logic               mem16_oe,
    input logic               io16_oe,
    input logic               mem_rd_cs,
    input logic               mem_wr_cs,
    input logic               io_rd_cs,
    input logic               io_wr_cs
);
    // R2
    mem16_tracks_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (mem16_oe == ($past(la_hi) == MEM_BASE[LA_W-1:0])));

    // R5
    mem_rd_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_cs |-> mem16_oe);

    // R6
    mem_wr_full_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem16_oe && $past(rst_n) && !$past(memw_n)) |-> mem_wr_cs);

    // R7
    io_sel_needs_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd_cs || io_wr_cs) |-> io16_oe);

    // R8
    io_sel_no_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd_cs || io_wr_cs) |-> ($past(rst_n) && !$past(aen)));

    // R10
    no_sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ior_n) && $past(iow_n) && $past(memr_n) && $past(memw_n)
         && !mem_rd_cs && !mem_wr_cs) |-> (!io_rd_cs && !io_wr_cs));

    // R3
    io16_unused_sa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(sa_hi)) |=> $stable(io16_oe));

endmodule

bind isa_width_decoder isa_width_decoder_chk #(
    .MEM_BASE(MEM_BASE),
    .LA_W    (LA_W),
    .SA_HI_W (SA_HI_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .la_hi    (la_hi),
    .sa_hi    (sa_hi),
    .aen      (aen),
    .ior_n    (ior_n),
    .iow_n    (iow_n),
    .memr_n   (memr_n),
    .memw_n   (memw_n),
    .mem16_oe (mem16_oe),
    .io16_oe  (io16_oe),
    .mem_rd_cs(mem_rd_cs),
    .mem_wr_cs(mem_wr_cs),
    .io_rd_cs (io_rd_cs),
    .io_wr_cs (io_wr_cs)
);

// File: tb/isa_width_decoder_tb.sv
module isa_width_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] la_hi = 7'h00;
    logic [6:0] sa_hi = 7'h00;
    logic       aen = 1'b0;
    logic       ior_n = 1'b1, iow_n = 1'b1;
    logic       smemr_n = 1'b1, smemw_n = 1'b1;
    logic       memr_n = 1'b1, memw_n = 1'b1;

    logic m16, i16, mrd, mwr, ird, iwr;
    logic h_m16, h_i16, h_mrd, h_mwr, h_ird, h_iwr;

    int checks = 0;
    int fails  = 0;

    localparam logic [6:0] WIN_LO = 7'h06;   // 0x0C0000, first MB
    localparam logic [6:0] WIN_HI = 7'h08;   // 0x100000, above first MB
    localparam logic [6:0] PORT   = 7'h60;   // 0x300 >> 3

    always #10 clk = ~clk;   // 50 MHz

    isa_width_decoder #(.MEM_BASE(WIN_LO), .IO_BASE(10'h300)) dut_i (
        .clk(clk), .rst_n(rst_n), .la_hi(la_hi), .sa_hi(sa_hi), .aen(aen),
        .ior_n(ior_n), .iow_n(iow_n), .smemr_n(smemr_n), .smemw_n(smemw_n),
        .memr_n(memr_n), .memw_n(memw_n),
        .mem16_oe(m16), .io16_oe(i16), .mem_rd_cs(mrd), .mem_wr_cs(mwr),
        .io_rd_cs(ird), .io_wr_cs(iwr)
    );

    isa_width_decoder #(.MEM_BASE(WIN_HI), .IO_BASE(10'h300)) dut_hi_i (
        .clk(clk), .rst_n(rst_n), .la_hi(la_hi), .sa_hi(sa_hi), .aen(aen),
        .ior_n(ior_n), .iow_n(iow_n), .smemr_n(smemr_n), .smemw_n(smemw_n),
        .memr_n(memr_n), .memw_n(memw_n),
        .mem16_oe(h_m16), .io16_oe(h_i16), .mem_rd_cs(h_mrd), .mem_wr_cs(h_mwr),
        .io_rd_cs(h_ird), .io_wr_cs(h_iwr)
    );

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: outputs {m16,i16,mrd,mwr,ird,iwr} actual %b expected %b",
                     req, act, exp);
        end
    endtask

    // strobes: {ior,iow,smemr,smemw,memr,memw} active-high request bits
    task automatic drive(input logic [6:0] la, input logic [6:0] sa, input logic dma,
                         input logic [5:0] stb);
        la_hi   = la;
        sa_hi   = sa;
        aen     = dma;
        ior_n   = ~stb[5];
        iow_n   = ~stb[4];
        smemr_n = ~stb[3];
        smemw_n = ~stb[2];
        memr_n  = ~stb[1];
        memw_n  = ~stb[0];
        @(negedge clk);   // one posedge passes: registered result is visible
    endtask

    function automatic logic [5:0] lo_out();
        return {m16, i16, mrd, mwr, ird, iwr};
    endfunction

    function automatic logic [5:0] hi_out();
        return {h_m16, h_i16, h_mrd, h_mwr, h_ird, h_iwr};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        drive(WIN_LO, PORT, 1'b0, 6'b111111);
        check("R1 in reset", lo_out(), 6'b000000);
        rst_n = 1'b1;
        drive(7'h00, 7'h00, 1'b0, 6'b000000);
        check("R1 after reset", lo_out(), 6'b000000);
    endtask

    task automatic t_addr_only();
        drive(WIN_LO, 7'h11, 1'b0, 6'b000000);
        check("R2 R10 mem addr only", lo_out(), 6'b100000);
        drive(7'h07, 7'h11, 1'b1, 6'b000000);
        check("R2 no match", lo_out(), 6'b000000);
        drive(7'h01, PORT, 1'b1, 6'b000000);
        check("R3 R10 io addr only aen high", lo_out(), 6'b010000);
        drive(7'h01, 7'h61, 1'b0, 6'b000000);
        check("R3 neighbour block", lo_out(), 6'b000000);
    endtask

    task automatic t_overlap();
        drive(WIN_LO, PORT, 1'b0, 6'b000000);
        check("R4 both width enables", lo_out(), 6'b110000);
        drive(WIN_LO, PORT, 1'b0, 6'b000010);
        check("R4 R5 overlap memr", lo_out(), 6'b111000);
        drive(WIN_LO, PORT, 1'b0, 6'b100000);
        check("R4 R7 overlap ior", lo_out(), 6'b110010);
        drive(WIN_LO, PORT, 1'b1, 6'b100000);
        check("R4 R8 overlap ior dma", lo_out(), 6'b110000);
    endtask

    task automatic t_memory();
        drive(WIN_LO, 7'h00, 1'b0, 6'b001000);
        check("R5 smemr low window", lo_out(), 6'b101000);
        drive(WIN_LO, 7'h00, 1'b0, 6'b000001);
        check("R6 memw", lo_out(), 6'b100100);
        drive(WIN_LO, 7'h00, 1'b0, 6'b000100);
        check("R6 smemw low window", lo_out(), 6'b100100);
        drive(7'h05, 7'h00, 1'b0, 6'b001111);
        check("R5 R6 strobes outside window", lo_out(), 6'b000000);
        drive(WIN_LO, 7'h00, 1'b1, 6'b000010);
        check("R8 mem select during dma", lo_out(), 6'b101000);
    endtask

    task automatic t_io();
        drive(7'h00, PORT, 1'b0, 6'b010000);
        check("R7 iow", lo_out(), 6'b010001);
        drive(7'h00, PORT, 1'b1, 6'b010000);
        check("R8 iow dma", lo_out(), 6'b010000);
        drive(7'h00, 7'h5F, 1'b0, 6'b110000);
        check("R7 strobes outside block", lo_out(), 6'b000000);
    endtask

    task automatic t_high_window();
        drive(WIN_HI, 7'h00, 1'b0, 6'b001100);
        check("R9 smem ignored high window", hi_out(), 6'b100000);
        drive(WIN_HI, 7'h00, 1'b0, 6'b000011);
        check("R9 memr memw high window", hi_out(), 6'b101100);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_addr_only();
        t_overlap();
        t_memory();
        t_io();
        t_high_window();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule